// File: doc/BRIEF.md
# Flash Window Segment Decoder

This block sits in front of a serial-flash controller that serves up to three flash devices through one memory-mapped region. Software gives each chip select a window of that region through a segment register. The register holds the first and the last 1 MiB granule of the window, and both ends are inclusive. For every bus access the block reports which chip select owns the address, or reports that no window covers it. When a chip select owns the address, the block also gives the byte offset inside that window.

Two more per-chip-select settings live in the block. A write-permission bit decides whether bus writes may reach a device. A wide-address flag tells the downstream serial engine to use 4-byte addresses for that device. A small register port lets software read and write all of these settings. The decode result is registered and appears one clock after the bus access is presented.

Top module: `flash_window_decoder`

## Requirements
- R1: While reset is asserted and after it is released, all decode outputs are low. The permission register and the address-mode register read 0. Segment register i reads as a 2 MiB window with first granule 2i and last granule 2i+1, which is 0x00100000, 0x00300020 and 0x00500040 for i = 0, 1, 2.
- R2: A valid access whose offset bits [27:20] lie between the first granule and the last granule of a window (both ends included) raises the one-hot bit of that chip select. The bit appears on the clock edge after the access is sampled.
- R3: A window whose first and last granule fields are both zero is disabled, and no access selects it. A window whose first granule is above its last granule never matches.
- R4: On a hit, dec_offset equals bus_offset minus the first granule shifted left by 20 bits. Bits [19:0] pass through unchanged.
- R5: When several windows cover the access, the lowest-numbered chip select wins, and at most one hit bit is ever high.
- R6: A valid access that no window covers raises dec_miss. It selects nothing and gives offset 0.
- R7: A valid write into a window whose permission bit (bit 16+cs of the register at offset 0x00) is clear produces no hit and no miss, and raises dec_wr_denied. Reads of such a window are not affected.
- R8: dec_addr4b is high on a hit exactly when bit cs or bit cs+4 of the register at offset 0x04 is set for the winning chip select. It is low on a miss, on a denied write and when idle.
- R9: Segment register cs sits at byte offset 0x30+4*cs. It stores the first granule in bits [11:4] and the last granule in bits [27:20]. Every other bit of every register reads as 0. A register write takes effect for accesses sampled on later edges, and reg_rdata returns the addressed register in the same cycle while reg_en is high.
- R10: A read of any other offset, a misaligned one included, returns 0. A write to such an offset changes neither any register nor any decode result.
- R11: dec_valid is high exactly one cycle after a cycle with bus_valid high. When dec_valid is low, dec_cs_hit, dec_miss and dec_wr_denied are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_en | input | 1 | Register port access strobe |
| reg_we | input | 1 | Register write when high, read when low |
| reg_addr | input | REG_AW | Register byte offset |
| reg_wdata | input | REG_DW | Register write data |
| reg_rdata | output | REG_DW | Register read data, combinational |
| bus_valid | input | 1 | Bus access present this cycle |
| bus_write | input | 1 | Bus access is a write |
| bus_offset | input | OFS_W | Byte offset into the flash region |
| dec_valid | output | 1 | A decode result is present |
| dec_cs_hit | output | NUM_CS | One-hot winning chip select |
| dec_offset | output | OFS_W | Offset inside the winning window |
| dec_miss | output | 1 | No window covers the access |
| dec_wr_denied | output | 1 | Write blocked by a clear permission bit |
| dec_addr4b | output | 1 | Winning chip select uses 4-byte addressing |

## Verification
The hardest case to reach from the ports is a bus access that arrives in the same cycle as a register write changing the same window or permission bit. The access must still be decoded against the settings that were in place before that write. The bench drives both ports in one cycle. A write to a blocked window coincides with the write that grants permission, and the reference model applies register writes only after it has computed that cycle's expected decode. Windows are reprogrammed into overlapping, inverted and zeroed forms, and accesses are placed on the first and last byte of each granule range.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

  // one window granule is 1 MiB
  localparam int unsigned FWD_GRAN_SHIFT    = 20;

  // register byte offsets
  localparam int unsigned FWD_OFS_CFG       = 'h00;
  localparam int unsigned FWD_OFS_CTL       = 'h04;
  localparam int unsigned FWD_OFS_SEG0      = 'h30;
  localparam int unsigned FWD_SEG_STRIDE    = 4;

  // field positions the downstream logic depends on
  localparam int unsigned FWD_WEN_LSB       = 16;
  localparam int unsigned FWD_A4_HI_LSB     = 4;
  localparam int unsigned FWD_SEG_FIRST_LSB = 4;
  localparam int unsigned FWD_SEG_LAST_LSB  = 20;

  typedef enum logic [1:0] {
    RES_IDLE = 2'd0,
    RES_HIT  = 2'd1,
    RES_MISS = 2'd2,
    RES_DENY = 2'd3
  } fwd_result_e;

  function automatic int unsigned fwd_seg_offset(input int unsigned cs);
    return FWD_OFS_SEG0 + cs * FWD_SEG_STRIDE;
  endfunction

endpackage

// File: rtl/fwd_regbank.sv
module fwd_regbank
  import fwd_pkg::*;
#(
  parameter int unsigned NUM_CS       = 3,
  parameter int unsigned AW           = 8,
  parameter int unsigned DW           = 32,
  parameter int unsigned GRAN_W       = 8,
  parameter int unsigned RST_WIN_GRAN = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          reg_en,
  input  logic                          reg_we,
  input  logic [AW-1:0]                 reg_addr,
  input  logic [DW-1:0]                 reg_wdata,
  output logic [DW-1:0]                 reg_rdata,
  output logic [NUM_CS-1:0][GRAN_W-1:0] seg_first,
  output logic [NUM_CS-1:0][GRAN_W-1:0] seg_last,
  output logic [NUM_CS-1:0]             seg_on,
  output logic [NUM_CS-1:0]             cs_wr_ok,
  output logic [NUM_CS-1:0]             cs_addr4b
);

  // address decode
  logic              sel_cfg;
  logic              sel_ctl;
  logic [NUM_CS-1:0] sel_seg;

  assign sel_cfg = reg_en && (reg_addr == AW'(FWD_OFS_CFG));
  assign sel_ctl = reg_en && (reg_addr == AW'(FWD_OFS_CTL));

  for (genvar gi = 0; gi < NUM_CS; gi++) begin : g_sel
    assign sel_seg[gi] = reg_en && (reg_addr == AW'(fwd_seg_offset(gi)));
  end

  // write strobes act as clock enables
  logic              ld_cfg;
  logic              ld_ctl;
  logic [NUM_CS-1:0] ld_seg;

  assign ld_cfg = sel_cfg && reg_we;
  assign ld_ctl = sel_ctl && reg_we;
  assign ld_seg = sel_seg & {NUM_CS{reg_we}};

  // next-state values extracted from the write data
  logic [NUM_CS-1:0] wen_d;
  logic [NUM_CS-1:0] a4lo_d;
  logic [NUM_CS-1:0] a4hi_d;
  logic [GRAN_W-1:0] first_d;
  logic [GRAN_W-1:0] last_d;

  always_comb begin
    for (int i = 0; i < NUM_CS; i++) begin
      wen_d[i]  = reg_wdata[FWD_WEN_LSB + i];
      a4lo_d[i] = reg_wdata[i];
      a4hi_d[i] = reg_wdata[FWD_A4_HI_LSB + i];
    end
    first_d = reg_wdata[FWD_SEG_FIRST_LSB +: GRAN_W];
    last_d  = reg_wdata[FWD_SEG_LAST_LSB +: GRAN_W];
  end

  logic unused_wdata_bits;
  assign unused_wdata_bits = ^reg_wdata;

  // state
  logic [NUM_CS-1:0]             wen_q;
  logic [NUM_CS-1:0]             a4lo_q;
  logic [NUM_CS-1:0]             a4hi_q;
  logic [NUM_CS-1:0][GRAN_W-1:0] first_q;
  logic [NUM_CS-1:0][GRAN_W-1:0] last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wen_q <= '0;
    end else if (ld_cfg) begin
      wen_q <= wen_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a4lo_q <= '0;
      a4hi_q <= '0;
    end else if (ld_ctl) begin
      a4lo_q <= a4lo_d;
      a4hi_q <= a4hi_d;
    end
  end

  for (genvar gs = 0; gs < NUM_CS; gs++) begin : g_seg
    localparam int unsigned RST_FIRST = gs * RST_WIN_GRAN;
    localparam int unsigned RST_LAST  = RST_FIRST + RST_WIN_GRAN - 1;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        first_q[gs] <= GRAN_W'(RST_FIRST);
        last_q[gs]  <= GRAN_W'(RST_LAST);
      end else if (ld_seg[gs]) begin
        first_q[gs] <= first_d;
        last_q[gs]  <= last_d;
      end
    end

    assign seg_on[gs] = (|first_q[gs]) || (|last_q[gs]);
  end

  // read mux, zero for any offset not decoded above
  always_comb begin
    reg_rdata = '0;
    if (sel_cfg) begin
      for (int i = 0; i < NUM_CS; i++) begin
        reg_rdata[FWD_WEN_LSB + i] = wen_q[i];
      end
    end
    if (sel_ctl) begin
      for (int i = 0; i < NUM_CS; i++) begin
        reg_rdata[i]                 = a4lo_q[i];
        reg_rdata[FWD_A4_HI_LSB + i] = a4hi_q[i];
      end
    end
    for (int i = 0; i < NUM_CS; i++) begin
      if (sel_seg[i]) begin
        reg_rdata[FWD_SEG_FIRST_LSB +: GRAN_W] = first_q[i];
        reg_rdata[FWD_SEG_LAST_LSB +: GRAN_W]  = last_q[i];
      end
    end
  end

  assign seg_first = first_q;
  assign seg_last  = last_q;
  assign cs_wr_ok  = wen_q;
  assign cs_addr4b = a4lo_q | a4hi_q;

endmodule

// File: rtl/fwd_window_cmp.sv
module fwd_window_cmp #(
  parameter int unsigned GRAN_W = 8
) (
  input  logic [GRAN_W-1:0] gran,
  input  logic [GRAN_W-1:0] first,
  input  logic [GRAN_W-1:0] last,
  input  logic              win_on,
  output logic              hit
);

  logic above_first;
  logic below_last;

  assign above_first = (gran >= first);
  assign below_last  = (gran <= last);
  assign hit         = win_on && above_first && below_last;

endmodule

// File: rtl/fwd_resolve.sv
module fwd_resolve
  import fwd_pkg::*;
#(
  parameter int unsigned NUM_CS = 3,
  parameter int unsigned OFS_W  = 28,
  parameter int unsigned GRAN_W = 8
) (
  input  logic                          bus_valid,
  input  logic                          bus_write,
  input  logic [OFS_W-1:0]              bus_offset,
  input  logic [NUM_CS-1:0]             raw_hit,
  input  logic [NUM_CS-1:0][GRAN_W-1:0] seg_first,
  input  logic [NUM_CS-1:0]             cs_wr_ok,
  input  logic [NUM_CS-1:0]             cs_addr4b,
  output fwd_result_e                   res,
  output logic [NUM_CS-1:0]             grant,
  output logic [OFS_W-1:0]              win_offset,
  output logic                          addr4b
);

  localparam int unsigned IDX_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;

  logic [GRAN_W-1:0] gran;
  logic [IDX_W-1:0]  idx;
  logic              found;

  assign gran = bus_offset[OFS_W-1 -: GRAN_W];

  // scan from the top so the lowest set index is kept last
  always_comb begin
    idx   = '0;
    found = 1'b0;
    for (int i = NUM_CS - 1; i >= 0; i--) begin
      if (raw_hit[i]) begin
        idx   = IDX_W'(i);
        found = 1'b1;
      end
    end
  end

  always_comb begin
    res        = RES_IDLE;
    grant      = '0;
    win_offset = '0;
    addr4b     = 1'b0;
    if (bus_valid) begin
      if (!found) begin
        res = RES_MISS;
      end else if (bus_write && !cs_wr_ok[idx]) begin
        res = RES_DENY;
      end else begin
        res        = RES_HIT;
        grant[idx] = 1'b1;
        win_offset = {gran - seg_first[idx], bus_offset[FWD_GRAN_SHIFT-1:0]};
        addr4b     = cs_addr4b[idx];
      end
    end
  end

endmodule

// File: rtl/flash_window_decoder.sv
module flash_window_decoder
  import fwd_pkg::*;
#(
  parameter int unsigned NUM_CS       = 3,
  parameter int unsigned OFS_W        = 28,
  parameter int unsigned REG_AW       = 8,
  parameter int unsigned REG_DW       = 32,
  parameter int unsigned RST_WIN_GRAN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_en,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [OFS_W-1:0]  bus_offset,
  output logic              dec_valid,
  output logic [NUM_CS-1:0] dec_cs_hit,
  output logic [OFS_W-1:0]  dec_offset,
  output logic              dec_miss,
  output logic              dec_wr_denied,
  output logic              dec_addr4b
);

  localparam int unsigned GRAN_W = OFS_W - FWD_GRAN_SHIFT;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // configuration registers
  logic [NUM_CS-1:0][GRAN_W-1:0] seg_first;
  logic [NUM_CS-1:0][GRAN_W-1:0] seg_last;
  logic [NUM_CS-1:0]             seg_on;
  logic [NUM_CS-1:0]             cs_wr_ok;
  logic [NUM_CS-1:0]             cs_addr4b;

  fwd_regbank #(
    .NUM_CS       (NUM_CS),
    .AW           (REG_AW),
    .DW           (REG_DW),
    .GRAN_W       (GRAN_W),
    .RST_WIN_GRAN (RST_WIN_GRAN)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .reg_en    (reg_en),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .seg_first (seg_first),
    .seg_last  (seg_last),
    .seg_on    (seg_on),
    .cs_wr_ok  (cs_wr_ok),
    .cs_addr4b (cs_addr4b)
  );

  // one comparator per window
  logic [NUM_CS-1:0] raw_hit;

  for (genvar gw = 0; gw < NUM_CS; gw++) begin : g_win
    fwd_window_cmp #(
      .GRAN_W (GRAN_W)
    ) u_cmp (
      .gran   (bus_offset[OFS_W-1 -: GRAN_W]),
      .first  (seg_first[gw]),
      .last   (seg_last[gw]),
      .win_on (seg_on[gw]),
      .hit    (raw_hit[gw])
    );
  end

  // priority, permission and offset
  fwd_result_e       res_d;
  logic [NUM_CS-1:0] grant_d;
  logic [OFS_W-1:0]  offset_d;
  logic              addr4b_d;

  fwd_resolve #(
    .NUM_CS (NUM_CS),
    .OFS_W  (OFS_W),
    .GRAN_W (GRAN_W)
  ) u_resolve (
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_offset (bus_offset),
    .raw_hit    (raw_hit),
    .seg_first  (seg_first),
    .cs_wr_ok   (cs_wr_ok),
    .cs_addr4b  (cs_addr4b),
    .res        (res_d),
    .grant      (grant_d),
    .win_offset (offset_d),
    .addr4b     (addr4b_d)
  );

  // output stage
  fwd_result_e       res_q;
  logic [NUM_CS-1:0] grant_q;
  logic [OFS_W-1:0]  offset_q;
  logic              addr4b_q;
  logic              out_ld;

  // load while an access arrives or a result must be cleared
  assign out_ld = bus_valid || (res_q != RES_IDLE);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      res_q    <= RES_IDLE;
      grant_q  <= '0;
      offset_q <= '0;
      addr4b_q <= 1'b0;
    end else if (out_ld) begin
      res_q    <= res_d;
      grant_q  <= grant_d;
      offset_q <= offset_d;
      addr4b_q <= addr4b_d;
    end
  end

  assign dec_valid     = (res_q != RES_IDLE);
  assign dec_cs_hit    = grant_q;
  assign dec_offset    = offset_q;
  assign dec_miss      = (res_q == RES_MISS);
  assign dec_wr_denied = (res_q == RES_DENY);
  assign dec_addr4b    = addr4b_q;

endmodule

// File: rtl/fwd_checker.sv
module fwd_checker
  import fwd_pkg::*;
#(
  parameter int unsigned NUM_CS = 3,
  parameter int unsigned OFS_W  = 28,
  parameter int unsigned REG_AW = 8,
  parameter int unsigned REG_DW = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [OFS_W-1:0]  bus_offset,
  input logic              reg_en,
  input logic [REG_AW-1:0] reg_addr,
  input logic [REG_DW-1:0] reg_rdata,
  input logic              dec_valid,
  input logic [NUM_CS-1:0] dec_cs_hit,
  input logic [OFS_W-1:0]  dec_offset,
  input logic              dec_miss,
  input logic              dec_wr_denied,
  input logic              dec_addr4b
);

  AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dec_cs_hit)); // R5

  AST_MISS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    dec_miss |-> (dec_cs_hit == '0) && !dec_wr_denied && !dec_addr4b && (dec_offset == '0)); // R6

  AST_OUTCOME_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> ($countones({(|dec_cs_hit), dec_miss, dec_wr_denied}) == 1)); // R6

  AST_DENY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    dec_wr_denied |-> $past(bus_write) && (dec_cs_hit == '0) && !dec_miss); // R7

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |=> dec_valid); // R11

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |=> !dec_valid && (dec_cs_hit == '0) && !dec_miss && !dec_wr_denied); // R11

  AST_LOW_BITS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_cs_hit != '0) |-> (dec_offset[FWD_GRAN_SHIFT-1:0] == $past(bus_offset[FWD_GRAN_SHIFT-1:0]))); // R4

  AST_WIDE_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    dec_addr4b |-> (dec_cs_hit != '0)); // R8

  AST_MISALIGNED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_en && (reg_addr[1:0] != 2'b00)) |-> (reg_rdata == '0)); // R10

endmodule

bind flash_window_decoder fwd_checker #(
  .NUM_CS (NUM_CS),
  .OFS_W  (OFS_W),
  .REG_AW (REG_AW),
  .REG_DW (REG_DW)
) u_fwd_checker (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .bus_valid     (bus_valid),
  .bus_write     (bus_write),
  .bus_offset    (bus_offset),
  .reg_en        (reg_en),
  .reg_addr      (reg_addr),
  .reg_rdata     (reg_rdata),
  .dec_valid     (dec_valid),
  .dec_cs_hit    (dec_cs_hit),
  .dec_offset    (dec_offset),
  .dec_miss      (dec_miss),
  .dec_wr_denied (dec_wr_denied),
  .dec_addr4b    (dec_addr4b)
);

// File: tb/flash_window_decoder_test.sv
`timescale 1ns/1ps
module flash_window_decoder_test;

  logic        clk;
  logic        rst_n;
  logic        reg_en;
  logic        reg_we;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        bus_valid;
  logic        bus_write;
  logic [27:0] bus_offset;
  logic        dec_valid;
  logic [2:0]  dec_cs_hit;
  logic [27:0] dec_offset;
  logic        dec_miss;
  logic        dec_wr_denied;
  logic        dec_addr4b;

  flash_window_decoder uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_en        (reg_en),
    .reg_we        (reg_we),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .reg_rdata     (reg_rdata),
    .bus_valid     (bus_valid),
    .bus_write     (bus_write),
    .bus_offset    (bus_offset),
    .dec_valid     (dec_valid),
    .dec_cs_hit    (dec_cs_hit),
    .dec_offset    (dec_offset),
    .dec_miss      (dec_miss),
    .dec_wr_denied (dec_wr_denied),
    .dec_addr4b    (dec_addr4b)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_checks = 0;
  int n_errors = 0;
  int cycles   = 0;

  // reference model state
  logic [31:0] m_cfg;
  logic [31:0] m_ctl;
  logic [31:0] m_seg [3];

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [7:0] a);
    case (a)
      8'h00:   return m_cfg;
      8'h04:   return m_ctl;
      8'h30:   return m_seg[0];
      8'h34:   return m_seg[1];
      8'h38:   return m_seg[2];
      default: return 32'h0;
    endcase
  endfunction

  task automatic m_write(input logic [7:0] a, input logic [31:0] d);
    case (a)
      8'h00:   m_cfg    = d & 32'h0007_0000;
      8'h04:   m_ctl    = d & 32'h0000_0077;
      8'h30:   m_seg[0] = d & 32'h0FF0_0FF0;
      8'h34:   m_seg[1] = d & 32'h0FF0_0FF0;
      8'h38:   m_seg[2] = d & 32'h0FF0_0FF0;
      default: ;
    endcase
  endtask

  // one clock: drive both ports, predict, compare after the edge
  task automatic cycle(input logic v, input logic w, input logic [27:0] off,
                       input logic ren, input logic rwe, input logic [7:0] ra,
                       input logic [31:0] wd, input string tag);
    int          win;
    logic        e_valid;
    logic [2:0]  e_hit;
    logic [27:0] e_off;
    logic        e_miss;
    logic        e_deny;
    logic        e_a4;
    bus_valid  = v;
    bus_write  = w;
    bus_offset = off;
    reg_en     = ren;
    reg_we     = rwe;
    reg_addr   = ra;
    reg_wdata  = wd;
    #1;
    if (ren && !rwe) chk(tag, "reg_rdata", reg_rdata, m_read(ra));
    win = -1;
    for (int c = 0; c < 3; c++) begin
      if (win < 0 && m_seg[c] != 0 &&
          off[27:20] >= m_seg[c][11:4] && off[27:20] <= m_seg[c][27:20]) win = c;
    end
    e_valid = v; e_hit = 3'b000; e_off = 28'h0; e_miss = 1'b0; e_deny = 1'b0; e_a4 = 1'b0;
    if (v) begin
      if (win < 0) e_miss = 1'b1;
      else if (w && !m_cfg[16 + win]) e_deny = 1'b1;
      else begin
        e_hit = 3'b001 << win;
        e_off = off - {m_seg[win][11:4], 20'h0};
        e_a4  = m_ctl[win] | m_ctl[win + 4];
      end
    end
    if (ren && rwe) m_write(ra, wd);
    @(posedge clk);
    @(negedge clk);
    chk("R11", "dec_valid", 32'(dec_valid), 32'(e_valid));
    chk(tag, "dec_cs_hit", 32'(dec_cs_hit), 32'(e_hit));
    chk("R4", "dec_offset", 32'(dec_offset), 32'(e_off));
    chk("R6", "dec_miss", 32'(dec_miss), 32'(e_miss));
    chk("R7", "dec_wr_denied", 32'(dec_wr_denied), 32'(e_deny));
    chk("R8", "dec_addr4b", 32'(dec_addr4b), 32'(e_a4));
  endtask

  task automatic bus_rd(input logic [27:0] off, input string tag);
    cycle(1'b1, 1'b0, off, 1'b0, 1'b0, 8'h00, 32'h0, tag);
  endtask

  task automatic bus_wr(input logic [27:0] off, input string tag);
    cycle(1'b1, 1'b1, off, 1'b0, 1'b0, 8'h00, 32'h0, tag);
  endtask

  task automatic reg_wr(input logic [7:0] a, input logic [31:0] d, input string tag);
    cycle(1'b0, 1'b0, 28'h0, 1'b1, 1'b1, a, d, tag);
  endtask

  task automatic reg_rd(input logic [7:0] a, input string tag);
    cycle(1'b0, 1'b0, 28'h0, 1'b1, 1'b0, a, 32'h0, tag);
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      n_errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      summary();
    end
  end

  initial begin
    m_cfg = 32'h0; m_ctl = 32'h0;
    m_seg[0] = 32'h0010_0000; m_seg[1] = 32'h0030_0020; m_seg[2] = 32'h0050_0040;
    rst_n = 1'b0; reg_en = 1'b0; reg_we = 1'b0; reg_addr = 8'h0; reg_wdata = 32'h0;
    bus_valid = 1'b0; bus_write = 1'b0; bus_offset = 28'h0;
    repeat (3) @(negedge clk);
    // R1: reset state seen at the ports while reset is held
    chk("R1", "dec_valid in reset", 32'(dec_valid), 32'h0);
    chk("R1", "dec_cs_hit in reset", 32'(dec_cs_hit), 32'h0);
    chk("R1", "dec_miss in reset", 32'(dec_miss), 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    reg_rd(8'h00, "R1");
    reg_rd(8'h04, "R1");
    reg_rd(8'h30, "R1");
    reg_rd(8'h34, "R1");
    reg_rd(8'h38, "R1");
    cycle(1'b0, 1'b0, 28'h000_0100, 1'b0, 1'b0, 8'h0, 32'h0, "R11");

    // R2: default windows, first and last bytes of each
    bus_rd(28'h000_1234, "R2");
    bus_rd(28'h01F_FFFF, "R2");
    bus_rd(28'h023_4567, "R2");
    bus_rd(28'h051_2345, "R2");
    bus_rd(28'h040_0000, "R2");
    bus_rd(28'h060_0000, "R6");
    bus_rd(28'hFFF_FFFF, "R6");

    // R7: write blocked, then granted in the same cycle as an access
    bus_wr(28'h000_1000, "R7");
    cycle(1'b1, 1'b1, 28'h000_1000, 1'b1, 1'b1, 8'h00, 32'h0001_0000, "R7");
    bus_wr(28'h000_1000, "R7");
    bus_wr(28'h030_0000, "R7");
    bus_rd(28'h030_0000, "R7");

    // R9: reprogram window 1 to granules 16..31
    reg_wr(8'h34, 32'h01F0_0100, "R9");
    reg_rd(8'h34, "R9");
    bus_rd(28'h0FF_FFFF, "R2");
    bus_rd(28'h100_0000, "R2");
    bus_rd(28'h1FF_FFFF, "R2");
    bus_rd(28'h200_0000, "R2");

    // R9: unused bits dropped; R5: overlap resolves to the lower chip select
    reg_wr(8'h38, 32'hF2F0_F10F, "R9");
    reg_rd(8'h38, "R9");
    bus_rd(28'h180_0000, "R5");
    bus_rd(28'h210_0000, "R5");
    bus_rd(28'h100_0000, "R5");

    // R3: zeroed and inverted windows
    reg_wr(8'h34, 32'h0, "R3");
    reg_rd(8'h34, "R3");
    bus_rd(28'h180_0000, "R3");
    reg_wr(8'h30, 32'h0, "R3");
    bus_rd(28'h000_1234, "R3");
    reg_wr(8'h30, 32'h0200_0400, "R3");
    bus_rd(28'h300_0000, "R3");
    bus_rd(28'h400_0000, "R3");
    bus_rd(28'h200_0000, "R3");

    // R8: wide-address flags through either bit
    reg_wr(8'h30, 32'h0010_0000, "R9");
    reg_wr(8'h04, 32'h0000_0010, "R8");
    bus_rd(28'h000_0100, "R8");
    bus_rd(28'h210_0000, "R8");
    reg_wr(8'h04, 32'h0000_0004, "R8");
    bus_rd(28'h000_0100, "R8");
    bus_rd(28'h210_0000, "R8");
    bus_wr(28'h210_0000, "R8");
    reg_wr(8'h04, 32'hFFFF_FFFF, "R9");
    reg_rd(8'h04, "R9");
    reg_wr(8'h00, 32'hFFFF_FFFF, "R9");
    reg_rd(8'h00, "R9");
    bus_wr(28'h210_0000, "R8");
    reg_wr(8'h00, 32'h0000_0000, "R7");
    bus_wr(28'h000_0100, "R7");

    // R10: reserved and misaligned offsets
    reg_wr(8'h08, 32'hFFFF_FFFF, "R10");
    reg_wr(8'h31, 32'hFFFF_FFFF, "R10");
    reg_wr(8'h3C, 32'hFFFF_FFFF, "R10");
    reg_wr(8'h10, 32'hFFFF_FFFF, "R10");
    reg_wr(8'h02, 32'hFFFF_FFFF, "R10");
    reg_rd(8'h08, "R10");
    reg_rd(8'h31, "R10");
    reg_rd(8'h3C, "R10");
    reg_rd(8'h02, "R10");
    reg_rd(8'h00, "R10");
    reg_rd(8'h30, "R10");
    reg_rd(8'h38, "R10");
    bus_wr(28'h000_0100, "R10");
    bus_rd(28'h100_0000, "R10");

    // R11: idle cycles between accesses
    cycle(1'b0, 1'b1, 28'h000_0100, 1'b0, 1'b0, 8'h0, 32'h0, "R11");
    bus_rd(28'h000_0100, "R11");
    cycle(1'b0, 1'b0, 28'h210_0000, 1'b0, 1'b0, 8'h0, 32'h0, "R11");

    // R2: granule sweep with alternating direction
    reg_wr(8'h00, 32'h0005_0000, "R7");
    for (int g = 0; g < 56; g++) begin
      cycle(1'b1, g[0], {g[7:0], 20'h0ABCD}, 1'b0, 1'b0, 8'h0, 32'h0, "R2");
    end

    summary();
  end

endmodule